// File: doc/BRIEF.md
# GPIO Bank with Per-Pin Interrupts

A bank of general-purpose pins reached through a small register bus. Each pin has its own group of registers: one selects whether the pin drives its pad, one returns the synchronized pad level and holds the value to drive, one configures interrupt detection, and one holds a pending status bit that software clears by writing a one. The number of pins is a parameter.

Interrupt detection is set per pin. A pin can detect one edge (rising or falling) or a level (high or low). Each pin also has a routing register that decides whether its interrupt can reach the single summary interrupt line sent to the processor. There is no both-edge mode. Software gets that behaviour by flipping the polarity after each event.

Pad inputs pass through a two-flop synchronizer before detection and before readback. Reads return data one cycle after the request, with a valid strobe.

Top module: `gpio_irq_bank`

## Requirements
- R1: After reset every pin is an input (`pad_oe` all 0), `pad_out` is all 0, every status bit reads 0, every routing register reads 7 and `summary_irq` is low.
- R2: Bit 9 of a pin's config register (pin group base 0x1000 + 0x10·pin, offset +0x0) drives that pin's `pad_oe` bit. A write to the data register (+0x4) sets the pin's `pad_out` bit from write-data bit 1. Reading the data register returns the driven value in bit 1.
- R3: Bit 0 of the data register returns the pad input after a two-flop synchronizer. A read issued on the cycle after a pad change still returns the old level, and the next read returns the new level.
- R4: With interrupt config (+0x8) bit 2 = 1 (edge) and bit 1 = 1, a rising pad edge sets status (+0xC) bit 0, and a falling edge sets nothing.
- R5: With bit 2 = 1 and bit 1 = 0, a falling pad edge sets status, and a rising edge sets nothing.
- R6: With bit 2 = 0 (level), status is set while the pad equals bit 1. Once set, status stays set after the level goes away.
- R7: Writing status with bit 0 = 1 clears it, and writing bit 0 = 0 leaves it unchanged. If a detection event occurs in the same cycle as the clear, the event wins, so a level that is still active keeps status set.
- R8: With interrupt config bit 3 (raw status enable) = 0, no event sets status, even with interrupt enable (bit 0) set.
- R9: `summary_irq` is high exactly when some pin has routing register (0x400 + 4·pin) equal to 4, interrupt enable set and status set. The routing value 7 blocks the pin, and clearing the enable blocks it without clearing status.
- R10: `bus_rvalid` is high the cycle after a read request and never after a write. Reads of unmapped addresses, of pins at or above the pin count, or of non-register offsets return 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Bus request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte address |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Read data, valid with bus_rvalid |
| bus_rvalid | output | 1 | Read data valid, one cycle after a read |
| pad_in | input | NUM_PINS | Asynchronous pad levels |
| pad_out | output | NUM_PINS | Value to drive on each pad |
| pad_oe | output | NUM_PINS | Tri-state enable per pad, 1 = drive |
| summary_irq | output | 1 | Combined interrupt toward the processor |

## Verification
Detection is tested with four pad patterns on separate pins: a single rising edge, a single falling edge, a held high level and a held low level. Each mode is paired with the pattern it must ignore, so the checks separate edge from level and one polarity from the other. A held level at the moment of a clear shows that the event wins over the clear, and a pin with raw status disabled shows that an event can be blocked before it reaches status. The summary line is toggled through routing and enable changes while status stays set, which separates the pending state from its delivery. Back-to-back reads right after a pad change check the two-cycle synchronizer latency.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    typedef enum logic [2:0] {
        KIND_NONE,
        KIND_CFG,
        KIND_DATA,
        KIND_ICFG,
        KIND_STAT,
        KIND_ROUTE
    } reg_kind_e;

    // interrupt configuration, bit 3 .. bit 0
    typedef struct packed {
        logic raw_en;
        logic edge_mode;
        logic pol;
        logic ien;
    } icfg_t;

    localparam int OE_BIT      = 9;
    localparam int OUT_BIT     = 1;
    localparam int IN_BIT      = 0;
    localparam int STAT_BIT    = 0;
    localparam int ICFG_W      = 4;
    localparam int ROUTE_W     = 3;

    localparam int GROUP_BASE  = 'h1000;
    localparam int GROUP_SHIFT = 4;
    localparam int ROUTE_BASE  = 'h400;
    localparam int ROUTE_SHIFT = 2;

    localparam logic [ROUTE_W-1:0] TARGET_CPU  = 3'd4;
    localparam logic [ROUTE_W-1:0] TARGET_NONE = 3'd7;

    function automatic logic detect_event(icfg_t c, logic cur, logic prev);
        logic hit;
        if (c.edge_mode) begin
            hit = c.pol ? (cur & ~prev) : (~cur & prev);
        end else begin
            hit = (cur == c.pol);
        end
        return hit;
    endfunction

    function automatic reg_kind_e group_kind(logic [GROUP_SHIFT-1:0] off);
        reg_kind_e k;
        case (off)
            4'h0:    k = KIND_CFG;
            4'h4:    k = KIND_DATA;
            4'h8:    k = KIND_ICFG;
            4'hC:    k = KIND_STAT;
            default: k = KIND_NONE;
        endcase
        return k;
    endfunction

endpackage

// File: rtl/gpio_sync2.sv
module gpio_sync2 #(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d,
    output logic [WIDTH-1:0] q
);
    logic [WIDTH-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/gpio_addr_decode.sv
module gpio_addr_decode
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 16,
    parameter int PIN_W    = 3
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_kind_e         kind,
    output logic [PIN_W-1:0]  pin
);
    localparam logic [ADDR_W-1:0] GBASE = ADDR_W'(GROUP_BASE);
    localparam logic [ADDR_W-1:0] RBASE = ADDR_W'(ROUTE_BASE);
    localparam logic [ADDR_W-1:0] NPINS = ADDR_W'(NUM_PINS);

    logic [ADDR_W-1:0] goff;
    logic [ADDR_W-1:0] roff;
    logic [ADDR_W-1:0] gidx;
    logic [ADDR_W-1:0] ridx;

    always_comb begin
        goff = addr - GBASE;
        roff = addr - RBASE;
        gidx = goff >> GROUP_SHIFT;
        ridx = roff >> ROUTE_SHIFT;
        kind = KIND_NONE;
        pin  = '0;
        if (addr >= GBASE && gidx < NPINS) begin
            kind = group_kind(goff[GROUP_SHIFT-1:0]);
            pin  = gidx[PIN_W-1:0];
        end else if (addr >= RBASE && roff[ROUTE_SHIFT-1:0] == '0 && ridx < NPINS) begin
            kind = KIND_ROUTE;
            pin  = ridx[PIN_W-1:0];
        end
    end
endmodule

// File: rtl/gpio_pin_unit.sv
module gpio_pin_unit
    import gpio_bank_pkg::*;
#(
    parameter int DATA_W = 32
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  reg_kind_e         kind,
    input  logic [DATA_W-1:0] wdata,
    input  logic              pad_sync,
    output logic              oe,
    output logic              out_val,
    output logic              irq_req,
    output logic [DATA_W-1:0] rd_word
);
    icfg_t              icfg;
    logic               status;
    logic               prev_in;
    logic [ROUTE_W-1:0] route;
    logic               evt;
    logic               clr;

    assign evt = detect_event(icfg, pad_sync, prev_in);
    assign clr = wr_en && kind == KIND_STAT && wdata[STAT_BIT];

    always_ff @(posedge clk) begin
        if (rst) begin
            oe      <= 1'b0;
            out_val <= 1'b0;
            icfg    <= '0;
            route   <= TARGET_NONE;
            prev_in <= 1'b0;
            status  <= 1'b0;
        end else begin
            prev_in <= pad_sync;
            if (icfg.raw_en && evt) begin
                status <= 1'b1;
            end else if (clr) begin
                status <= 1'b0;
            end
            if (wr_en) begin
                case (kind)
                    KIND_CFG:   oe      <= wdata[OE_BIT];
                    KIND_DATA:  out_val <= wdata[OUT_BIT];
                    KIND_ICFG:  icfg    <= icfg_t'(wdata[ICFG_W-1:0]);
                    KIND_ROUTE: route   <= wdata[ROUTE_W-1:0];
                    default:    ;
                endcase
            end
        end
    end

    assign irq_req = status && icfg.ien && route == TARGET_CPU;

    always_comb begin
        rd_word = '0;
        case (kind)
            KIND_CFG:   rd_word[OE_BIT] = oe;
            KIND_DATA: begin
                rd_word[OUT_BIT] = out_val;
                rd_word[IN_BIT]  = pad_sync;
            end
            KIND_ICFG:  rd_word[ICFG_W-1:0]  = icfg;
            KIND_STAT:  rd_word[STAT_BIT]    = status;
            KIND_ROUTE: rd_word[ROUTE_W-1:0] = route;
            default:    ;
        endcase
    end
endmodule

// File: rtl/gpio_irq_bank.sv
module gpio_irq_bank
    import gpio_bank_pkg::*;
#(
    parameter int NUM_PINS = 8,
    parameter int ADDR_W   = 16,
    parameter int DATA_W   = 32
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                bus_sel,
    input  logic                bus_we,
    input  logic [ADDR_W-1:0]   bus_addr,
    input  logic [DATA_W-1:0]   bus_wdata,
    output logic [DATA_W-1:0]   bus_rdata,
    output logic                bus_rvalid,
    input  logic [NUM_PINS-1:0] pad_in,
    output logic [NUM_PINS-1:0] pad_out,
    output logic [NUM_PINS-1:0] pad_oe,
    output logic                summary_irq
);
    localparam int PIN_W = (NUM_PINS > 1) ? $clog2(NUM_PINS) : 1;

    logic [NUM_PINS-1:0] pad_sync;
    logic [NUM_PINS-1:0] irq_vec;
    logic [DATA_W-1:0]   words [NUM_PINS];
    reg_kind_e           kind;
    logic [PIN_W-1:0]    pin_idx;
    logic                unused_pin_bits;

    assign unused_pin_bits = ^{bus_wdata};

    gpio_sync2 #(.WIDTH(NUM_PINS)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (pad_in),
        .q   (pad_sync)
    );

    gpio_addr_decode #(
        .NUM_PINS (NUM_PINS),
        .ADDR_W   (ADDR_W),
        .PIN_W    (PIN_W)
    ) u_dec (
        .addr (bus_addr),
        .kind (kind),
        .pin  (pin_idx)
    );

    for (genvar i = 0; i < NUM_PINS; i++) begin : g_pin
        logic wr_here;
        assign wr_here = bus_sel && bus_we && kind != KIND_NONE && pin_idx == PIN_W'(i);

        gpio_pin_unit #(.DATA_W(DATA_W)) u_pin (
            .clk      (clk),
            .rst      (rst),
            .wr_en    (wr_here),
            .kind     (kind),
            .wdata    (bus_wdata),
            .pad_sync (pad_sync[i]),
            .oe       (pad_oe[i]),
            .out_val  (pad_out[i]),
            .irq_req  (irq_vec[i]),
            .rd_word  (words[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
        end else begin
            bus_rvalid <= bus_sel && !bus_we;
            if (bus_sel && !bus_we) begin
                bus_rdata <= (kind != KIND_NONE) ? words[pin_idx] : '0;
            end
        end
    end

    assign summary_irq = |irq_vec;
endmodule

// File: rtl/gpio_irq_bank_chk.sv
module gpio_irq_bank_chk #(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic                bus_sel,
    input logic                bus_we,
    input logic                bus_rvalid,
    input logic [NUM_PINS-1:0] pad_oe,
    input logic [NUM_PINS-1:0] pad_out,
    input logic                summary_irq
);
    assert_reset_quiet_R1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (!summary_irq && pad_oe == '0 && pad_out == '0));

    assert_oe_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> $stable(pad_oe));

    assert_out_hold_R2: assert property (@(posedge clk) disable iff (rst)
        !bus_sel |=> $stable(pad_out));

    assert_rvalid_follows_R10: assert property (@(posedge clk) disable iff (rst)
        (bus_sel && !bus_we) |=> bus_rvalid);

    assert_rvalid_source_R10: assert property (@(posedge clk) disable iff (rst)
        (!bus_sel || bus_we) |=> !bus_rvalid);
endmodule

bind gpio_irq_bank gpio_irq_bank_chk #(.NUM_PINS(NUM_PINS)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_sel     (bus_sel),
    .bus_we      (bus_we),
    .bus_rvalid  (bus_rvalid),
    .pad_oe      (pad_oe),
    .pad_out     (pad_out),
    .summary_irq (summary_irq)
);

// File: tb/gpio_irq_bank_test.sv
`timescale 1ns/1ps
module gpio_irq_bank_test;
    localparam int N = 8;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_sel = 1'b0;
    logic        bus_we = 1'b0;
    logic [15:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic [N-1:0] pad_in = '0;
    logic [N-1:0] pad_out;
    logic [N-1:0] pad_oe;
    logic        summary_irq;

    int checks = 0;
    int errors = 0;
    bit done   = 1'b0;

    typedef struct {
        logic [31:0] exp;
        string       tag;
    } item_t;
    item_t sb[$];

    always #2.5 clk = ~clk;

    gpio_irq_bank #(.NUM_PINS(N)) uut (
        .clk (clk), .rst (rst),
        .bus_sel (bus_sel), .bus_we (bus_we), .bus_addr (bus_addr),
        .bus_wdata (bus_wdata), .bus_rdata (bus_rdata), .bus_rvalid (bus_rvalid),
        .pad_in (pad_in), .pad_out (pad_out), .pad_oe (pad_oe),
        .summary_irq (summary_irq)
    );

    function automatic logic [15:0] a_cfg(int p);   return 16'(32'h1000 + 16 * p); endfunction
    function automatic logic [15:0] a_data(int p);  return 16'(32'h1004 + 16 * p); endfunction
    function automatic logic [15:0] a_icfg(int p);  return 16'(32'h1008 + 16 * p); endfunction
    function automatic logic [15:0] a_stat(int p);  return 16'(32'h100C + 16 * p); endfunction
    function automatic logic [15:0] a_route(int p); return 16'(32'h0400 + 4 * p); endfunction

    // monitor: pops the expected read from the scoreboard
    always @(negedge clk) begin
        if (!rst && bus_rvalid) begin
            checks++;
            if (sb.size() == 0) begin
                errors++;
                $display("FAIL R10 unexpected read data: actual %h expected none", bus_rdata);
            end else begin
                item_t it;
                it = sb.pop_front();
                if (bus_rdata !== it.exp) begin
                    errors++;
                    $display("FAIL %s: actual %h expected %h", it.tag, bus_rdata, it.exp);
                end
            end
        end
    end

    task automatic wr(logic [15:0] a, logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_we = 1'b0;
    endtask

    task automatic rd(logic [15:0] a, logic [31:0] e, string tag);
        item_t it;
        it.exp = e; it.tag = tag;
        sb.push_back(it);
        @(negedge clk);
        bus_sel = 1'b1; bus_we = 1'b0; bus_addr = a;
        @(negedge clk);
        bus_sel = 1'b0;
    endtask

    task automatic chk(logic [31:0] act, logic [31:0] e, string tag);
        checks++;
        if (act !== e) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", tag, act, e);
        end
    endtask

    task automatic settle();
        repeat (4) @(negedge clk);
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (2000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            finish_run();
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);

        // R1 reset state
        chk(32'(pad_oe), 0, "R1 pad_oe");
        chk(32'(pad_out), 0, "R1 pad_out");
        chk(32'(summary_irq), 0, "R1 summary");
        rd(a_route(0), 7, "R1 route0");
        rd(a_route(N - 1), 7, "R1 route last");
        rd(a_stat(3), 0, "R1 status");
        rd(a_cfg(1), 0, "R1 cfg");

        // R2 output enable and driven value
        wr(a_cfg(1), 32'h200);
        chk(32'(pad_oe), 32'h02, "R2 pad_oe");
        chk(32'(bus_rvalid), 0, "R10 no rvalid on write");
        wr(a_data(1), 32'h2);
        chk(32'(pad_out), 32'h02, "R2 pad_out set");
        rd(a_cfg(1), 32'h200, "R2 cfg readback");
        rd(a_data(1), 32'h2, "R2 data readback");
        wr(a_data(1), 32'hFFFF_FFFD);
        chk(32'(pad_out), 0, "R2 pad_out cleared by bit1");
        wr(a_cfg(1), 32'h0);
        chk(32'(pad_oe), 0, "R2 pad_oe cleared");

        // R3 synchronizer latency
        pad_in[4] = 1'b1;
        rd(a_data(4), 32'h0, "R3 first read old level");
        rd(a_data(4), 32'h1, "R3 second read new level");

        // R4 rising edge on pin 0, R7 clear behaviour
        wr(a_icfg(0), 32'hF);
        rd(a_icfg(0), 32'hF, "R4 icfg readback");
        pad_in[0] = 1'b1; settle();
        rd(a_stat(0), 1, "R4 rising sets status");
        chk(32'(summary_irq), 0, "R9 unrouted pin silent");
        wr(a_stat(0), 32'h0);
        rd(a_stat(0), 1, "R7 write zero ignored");
        wr(a_stat(0), 32'h1);
        rd(a_stat(0), 0, "R7 write one clears");
        pad_in[0] = 1'b0; settle();
        rd(a_stat(0), 0, "R4 falling ignored");

        // R5 falling edge on pin 7
        wr(a_icfg(7), 32'hD);
        pad_in[7] = 1'b1; settle();
        rd(a_stat(7), 0, "R5 rising ignored");
        pad_in[7] = 1'b0; settle();
        rd(a_stat(7), 1, "R5 falling sets status");
        wr(a_stat(7), 32'h1);
        rd(a_stat(7), 0, "R7 clear pin7");

        // R6 level low on pin 5 (pad already low)
        wr(a_icfg(5), 32'h9); settle();
        rd(a_stat(5), 1, "R6 level low sets");
        wr(a_stat(5), 32'h1);
        rd(a_stat(5), 1, "R7 active level beats clear");
        pad_in[5] = 1'b1; settle();
        wr(a_stat(5), 32'h1);
        rd(a_stat(5), 0, "R6 clear after level gone");

        // R6 level high on pin 6
        wr(a_icfg(6), 32'hB);
        pad_in[6] = 1'b1; settle();
        rd(a_stat(6), 1, "R6 level high sets");
        pad_in[6] = 1'b0; settle();
        rd(a_stat(6), 1, "R6 status stays latched");
        wr(a_stat(6), 32'h1);
        rd(a_stat(6), 0, "R6 clear level high");

        // R8 raw status disabled on pin 2
        wr(a_icfg(2), 32'h7);
        pad_in[2] = 1'b1; settle();
        rd(a_stat(2), 0, "R8 no latch without raw enable");
        pad_in[2] = 1'b0; settle();
        rd(a_stat(2), 0, "R8 still clear");

        // R9 summary routing on pin 3
        wr(a_route(3), 32'h4);
        rd(a_route(3), 32'h4, "R9 route readback");
        wr(a_icfg(3), 32'hF);
        chk(32'(summary_irq), 0, "R9 no status no summary");
        pad_in[3] = 1'b1; settle();
        chk(32'(summary_irq), 1, "R9 summary asserted");
        wr(a_route(3), 32'h7);
        chk(32'(summary_irq), 0, "R9 route none blocks");
        wr(a_route(3), 32'h4);
        chk(32'(summary_irq), 1, "R9 route cpu restores");
        wr(a_icfg(3), 32'hE);
        chk(32'(summary_irq), 0, "R9 enable clear blocks");
        rd(a_stat(3), 1, "R9 status kept with enable clear");
        wr(a_icfg(3), 32'hF);
        chk(32'(summary_irq), 1, "R9 enable restores");
        wr(a_stat(3), 32'h1);
        chk(32'(summary_irq), 0, "R9 clear drops summary");

        // R10 unmapped reads
        rd(16'h0800, 0, "R10 unmapped");
        rd(16'(32'h1000 + 16 * N), 0, "R10 pin beyond count");
        rd(16'h1002, 0, "R10 odd offset");
        rd(16'(32'h0400 + 4 * N), 0, "R10 route beyond count");

        repeat (3) @(negedge clk);
        checks++;
        if (sb.size() != 0) begin
            errors++;
            $display("FAIL R10 missing read data: actual %0d pending expected 0", sb.size());
        end
        done = 1'b1;
        finish_run();
    end
endmodule